// File: doc/BRIEF.md
# Dual Gated Timer/Counter

This block holds two 16-bit timer/counter channels for a small microcontroller subsystem. Each channel advances on the shared internal tick or on falling edges of its own count pin, and it can be gated by its external interrupt pin. Four counting modes are available: a 13-bit prescaled counter, a plain 16-bit counter, an 8-bit counter that reloads from the high byte, and a split mode that turns channel 0 into two 8-bit counters.

The CPU configures and observes the block over a byte-wide register bus with a combinational read path. The block also handles two external interrupt pins. Each pin can request an interrupt on a falling edge, latched in a flag, or on a low level. Overflow and external-edge flags drive the interrupt request outputs. An acknowledge strobe from the interrupt controller clears the matching flag.

Top module: `dtu_top`

## Requirements
- R1: Register addresses are 0 for mode, 1 for control, 2 and 3 for the low and high bytes of channel 0, and 4 and 5 for the low and high bytes of channel 1. All registers read 0 after reset, and both interrupt outputs are 0.
- R2: In the mode register, channel 1 uses bits [7:4] and channel 0 uses bits [3:0]. Within each nibble, bit 3 is gate, bit 2 is the external-source select, and bits [1:0] are the mode. The control register holds, from bit 7 down to bit 0: overflow flag 1, run 1, overflow flag 0, run 0, edge flag 1, type 1, edge flag 0, type 0.
- R3: When a channel's gate bit is 1, that channel advances only while its synchronised interrupt pin is high.
- R4: When the source select is 0, the channel advances on each cycle with tick_en high. When it is 1, the channel ignores tick_en and advances exactly once for each falling edge of its count pin, after a two-flop synchroniser.
- R5: While a channel's run bit is 0, its count holds.
- R6: An overflow sets that channel's overflow flag. irq_ovf equals the flag.
- R7: An overflow flag is cleared by writing 0 to it or by its ack_ovf strobe. If a hardware set falls in the same cycle as either clear, the set wins.
- R8: With type 1 set, a falling edge on an interrupt pin sets its edge flag, and irq_xint follows the flag. ack_xint clears the flag.
- R9: With type 0, irq_xint equals the inverted synchronised pin level, and the edge flag is not set.
- R10: Mode 0 counts a 13-bit value made of the high byte and low bits [4:0]. Low bits [7:5] are kept, and the overflow comes from the all-ones value.
- R11: Mode 1 counts 16 bits and overflows from 0xFFFF to 0x0000.
- R12: Mode 2 counts the low byte. On overflow the low byte loads the high byte, and the high byte does not change.
- R13: In mode 3, channel 0's low byte uses channel 0's controls and flag. Channel 0's high byte counts ticks while run 1 is set, and its overflow sets flag 1. Channel 1 in mode 3 holds its count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for reg_addr (combinational) |
| tick_en | input | 1 | Internal timer tick |
| cnt_pin | input | 2 | Count input pins, one per channel |
| xint_pin | input | 2 | External interrupt / gate pins |
| ack_ovf | input | 2 | Overflow interrupt acknowledge |
| ack_xint | input | 2 | External interrupt acknowledge |
| irq_ovf | output | 2 | Overflow interrupt requests |
| irq_xint | output | 2 | External interrupt requests |

## Verification
A table of preloads and tick counts drives channel 0 through every mode. It separates the 13-bit split from a plain 16-bit count, a kept upper prescaler bit from a cleared one, and reload from wrap. A separate pattern supplies slow pin edges while tick_en is held high, which shows whether the count follows edges rather than ticks or levels. A pin held low with ticks present separates gating from run control. An overflow that coincides with a control write, and later with an acknowledge, shows whether the hardware set wins over the clear.

// File: rtl/dtu_pkg.sv
package dtu_pkg;
  localparam int CNT_W  = 16;
  localparam int BYTE_W = 8;
  localparam int PRE_W  = 5;
  localparam int NCH    = 2;
  localparam int SEG_W  = BYTE_W + PRE_W;

  localparam logic [2:0] A_MODE = 3'd0;
  localparam logic [2:0] A_CTRL = 3'd1;
  localparam logic [2:0] A_CNT  = 3'd2;

  typedef enum logic [1:0] {
    MD_13    = 2'd0,
    MD_16    = 2'd1,
    MD_RLD   = 2'd2,
    MD_SPLIT = 2'd3
  } tmode_e;

  typedef struct packed {
    logic   gate;
    logic   ext;
    tmode_e mode;
  } chan_cfg_t;

  typedef struct packed {
    logic [CNT_W-1:0] cnt;
    logic             ovf;
  } step_t;

  // one advance of the low part of a channel in the given mode
  function automatic step_t step_count(tmode_e m, logic [CNT_W-1:0] c);
    step_t r;
    logic [SEG_W-1:0] seg;
    r.cnt = c;
    r.ovf = 1'b0;
    seg   = {c[CNT_W-1:BYTE_W], c[PRE_W-1:0]};
    case (m)
      MD_13: begin
        r.ovf = &seg;
        seg   = seg + 1'b1;
        r.cnt = {seg[SEG_W-1:PRE_W], c[BYTE_W-1:PRE_W], seg[PRE_W-1:0]};
      end
      MD_16: begin
        r.ovf = &c;
        r.cnt = c + 1'b1;
      end
      MD_RLD: begin
        r.ovf = &c[BYTE_W-1:0];
        r.cnt = {c[CNT_W-1:BYTE_W],
                 r.ovf ? c[CNT_W-1:BYTE_W] : c[BYTE_W-1:0] + 1'b1};
      end
      MD_SPLIT: begin
        r.ovf = &c[BYTE_W-1:0];
        r.cnt = {c[CNT_W-1:BYTE_W], c[BYTE_W-1:0] + 1'b1};
      end
    endcase
    return r;
  endfunction

  // flag update: software value, then ack clear, then hardware set wins
  function automatic logic flag_next(logic cur, logic sw_wr, logic sw_val,
                                     logic ack, logic hw_set);
    logic f;
    f = cur;
    if (sw_wr)  f = sw_val;
    if (ack)    f = 1'b0;
    if (hw_set) f = 1'b1;
    return f;
  endfunction
endpackage

// File: rtl/dtu_sync.sv
module dtu_sync #(
  parameter int N      = 2,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] din,
  output logic [N-1:0] lvl,
  output logic [N-1:0] fall
);
  localparam int DEPTH = STAGES + 1;

  for (genvar i = 0; i < N; i++) begin : g_bit
    logic [DEPTH-1:0] sh;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sh <= '1;
      else        sh <= {sh[DEPTH-2:0], din[i]};
    end
    assign lvl[i]  = sh[STAGES-1];
    assign fall[i] = sh[STAGES] & ~sh[STAGES-1];
  end
endmodule

// File: rtl/dtu_channel.sv
module dtu_channel
  import dtu_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  tmode_e            mode,
  input  logic              inc_lo,
  input  logic              inc_hi,
  input  logic              wr_lo,
  input  logic              wr_hi,
  input  logic [BYTE_W-1:0] wdata,
  output logic [CNT_W-1:0]  cnt,
  output logic              ovf_lo,
  output logic              ovf_hi
);
  logic [CNT_W-1:0] cnt_d;
  step_t            st;
  logic             split;

  assign st     = step_count(mode, cnt);
  assign split  = (mode == MD_SPLIT);
  assign ovf_lo = inc_lo & st.ovf;
  assign ovf_hi = split & inc_hi & (&cnt[CNT_W-1:BYTE_W]);

  always_comb begin
    cnt_d = cnt;
    if (inc_lo) cnt_d = st.cnt;
    if (split && inc_hi) cnt_d[CNT_W-1:BYTE_W] = cnt[CNT_W-1:BYTE_W] + 1'b1;
    if (wr_lo) cnt_d[BYTE_W-1:0] = wdata;
    if (wr_hi) cnt_d[CNT_W-1:BYTE_W] = wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt <= '0;
    else        cnt <= cnt_d;
  end
endmodule

// File: rtl/dtu_xint.sv
module dtu_xint
  import dtu_pkg::*;
(
  input  logic           clk,
  input  logic           rst_n,
  input  logic [NCH-1:0] fall,
  input  logic [NCH-1:0] lvl,
  input  logic [NCH-1:0] edge_sel,
  input  logic [NCH-1:0] ack,
  input  logic           sw_wr,
  input  logic [NCH-1:0] sw_val,
  output logic [NCH-1:0] flag,
  output logic [NCH-1:0] irq,
  output logic [NCH-1:0] set_evt
);
  for (genvar i = 0; i < NCH; i++) begin : g_pin
    assign set_evt[i] = edge_sel[i] & fall[i];
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) flag[i] <= 1'b0;
      else        flag[i] <= flag_next(flag[i], sw_wr, sw_val[i], ack[i], set_evt[i]);
    end
    assign irq[i] = edge_sel[i] ? flag[i] : ~lvl[i];
  end
endmodule

// File: rtl/dtu_top.sv
module dtu_top
  import dtu_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       reg_wr,
  input  logic [2:0] reg_addr,
  input  logic [7:0] reg_wdata,
  output logic [7:0] reg_rdata,
  input  logic       tick_en,
  input  logic [1:0] cnt_pin,
  input  logic [1:0] xint_pin,
  input  logic [1:0] ack_ovf,
  input  logic [1:0] ack_xint,
  output logic [1:0] irq_ovf,
  output logic [1:0] irq_xint
);
  localparam int NIB = BYTE_W / NCH;

  logic [BYTE_W-1:0] mode_q;
  logic [NCH-1:0]    run_q, tflag_q, itype_q, xflag;
  logic [NCH-1:0]    unused_cnt_lvl, cnt_fall, xint_lvl, xint_fall, xset_evt;
  logic [NCH-1:0]    src, open_g, inc_lo, inc_hi, wr_lo, wr_hi;
  logic [NCH-1:0]    ovf_lo, ovf_hi, ovf_set;
  logic [CNT_W-1:0]  cnt_all [NCH];
  chan_cfg_t         cfg [NCH];
  logic              wr_mode, wr_ctrl;

  dtu_sync #(.N(NCH), .STAGES(SYNC_STAGES)) u_cnt_sync (
    .clk(clk), .rst_n(rst_n), .din(cnt_pin), .lvl(unused_cnt_lvl), .fall(cnt_fall));

  dtu_sync #(.N(NCH), .STAGES(SYNC_STAGES)) u_xint_sync (
    .clk(clk), .rst_n(rst_n), .din(xint_pin), .lvl(xint_lvl), .fall(xint_fall));

  assign wr_mode = reg_wr && (reg_addr == A_MODE);
  assign wr_ctrl = reg_wr && (reg_addr == A_CTRL);

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    assign cfg[i]    = chan_cfg_t'(mode_q[NIB*i +: NIB]);
    assign wr_lo[i]  = reg_wr && (reg_addr == A_CNT + 3'(2*i));
    assign wr_hi[i]  = reg_wr && (reg_addr == A_CNT + 3'(2*i+1));
    assign src[i]    = cfg[i].ext ? cnt_fall[i] : tick_en;
    assign open_g[i] = run_q[i] & (~cfg[i].gate | xint_lvl[i]);
    if (i == 0) begin : g_lead
      assign inc_lo[i] = src[i] & open_g[i];
      assign inc_hi[i] = (cfg[i].mode == MD_SPLIT) & run_q[NCH-1] & tick_en;
    end else begin : g_follow
      assign inc_lo[i] = src[i] & open_g[i] & (cfg[i].mode != MD_SPLIT);
      assign inc_hi[i] = 1'b0;
    end

    dtu_channel u_ch (
      .clk(clk), .rst_n(rst_n), .mode(cfg[i].mode),
      .inc_lo(inc_lo[i]), .inc_hi(inc_hi[i]),
      .wr_lo(wr_lo[i]), .wr_hi(wr_hi[i]), .wdata(reg_wdata),
      .cnt(cnt_all[i]), .ovf_lo(ovf_lo[i]), .ovf_hi(ovf_hi[i]));
  end

  // channel 0 high byte in split mode reports through flag 1
  assign ovf_set[0] = ovf_lo[0];
  assign ovf_set[1] = ovf_lo[1] | ovf_hi[0] | ovf_hi[1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q  <= '0;
      run_q   <= '0;
      itype_q <= '0;
      tflag_q <= '0;
    end else begin
      if (wr_mode) mode_q <= reg_wdata;
      if (wr_ctrl) begin
        run_q   <= {reg_wdata[6], reg_wdata[4]};
        itype_q <= {reg_wdata[2], reg_wdata[0]};
      end
      tflag_q[0] <= flag_next(tflag_q[0], wr_ctrl, reg_wdata[5], ack_ovf[0], ovf_set[0]);
      tflag_q[1] <= flag_next(tflag_q[1], wr_ctrl, reg_wdata[7], ack_ovf[1], ovf_set[1]);
    end
  end

  dtu_xint u_xint (
    .clk(clk), .rst_n(rst_n), .fall(xint_fall), .lvl(xint_lvl),
    .edge_sel(itype_q), .ack(ack_xint), .sw_wr(wr_ctrl),
    .sw_val({reg_wdata[3], reg_wdata[1]}),
    .flag(xflag), .irq(irq_xint), .set_evt(xset_evt));

  assign irq_ovf = tflag_q;

  always_comb begin
    case (reg_addr)
      3'd0:    reg_rdata = mode_q;
      3'd1:    reg_rdata = {tflag_q[1], run_q[1], tflag_q[0], run_q[0],
                            xflag[1], itype_q[1], xflag[0], itype_q[0]};
      3'd2:    reg_rdata = cnt_all[0][BYTE_W-1:0];
      3'd3:    reg_rdata = cnt_all[0][CNT_W-1:BYTE_W];
      3'd4:    reg_rdata = cnt_all[1][BYTE_W-1:0];
      3'd5:    reg_rdata = cnt_all[1][CNT_W-1:BYTE_W];
      default: reg_rdata = '0;
    endcase
  end
endmodule

// File: rtl/dtu_checker.sv
module dtu_checker
  import dtu_pkg::*;
(
  input logic        clk,
  input logic        rst_n,
  input logic [1:0]  run,
  input logic        gate0,
  input logic [1:0]  mode0,
  input logic        xlvl0,
  input logic        xfall0,
  input logic        type0,
  input logic        xflag0,
  input logic        wr_lo0,
  input logic        wr_hi0,
  input logic [15:0] cnt0,
  input logic [1:0]  ovf_set,
  input logic [1:0]  tflag,
  input logic [1:0]  ack_ovf,
  input logic        ack_xint0
);
  p_stop_holds_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!run[0] && !wr_lo0) |=> cnt0[7:0] == $past(cnt0[7:0]));

  p_gate_blocks_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (gate0 && !xlvl0 && !wr_lo0) |=> cnt0[7:0] == $past(cnt0[7:0]));

  p_ovf_sets_flag_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_set[0] |=> tflag[0]);

  p_set_beats_ack_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf_set[1] && ack_ovf[1]) |=> tflag[1]);

  p_ack_clears_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_ovf[0] && !ovf_set[0]) |=> !tflag[0]);

  p_xedge_sets_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (xfall0 && type0 && !ack_xint0) |=> xflag0);

  p_single_step_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (mode0 == 2'd1 && !wr_lo0 && !wr_hi0) |=>
      (cnt0 == $past(cnt0) || cnt0 == 16'($past(cnt0) + 16'd1)));
endmodule

bind dtu_top dtu_checker u_chk (
  .clk(clk), .rst_n(rst_n), .run(run_q), .gate0(cfg[0].gate),
  .mode0(cfg[0].mode), .xlvl0(xint_lvl[0]), .xfall0(xint_fall[0]),
  .type0(itype_q[0]), .xflag0(xflag[0]), .wr_lo0(wr_lo[0]),
  .wr_hi0(wr_hi[0]), .cnt0(cnt_all[0]), .ovf_set(ovf_set),
  .tflag(tflag_q), .ack_ovf(ack_ovf), .ack_xint0(ack_xint[0]));

// File: tb/tb_dtu_top.sv
module tb_dtu_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       reg_wr = 1'b0;
  logic [2:0] reg_addr = '0;
  logic [7:0] reg_wdata = '0;
  logic [7:0] reg_rdata;
  logic       tick_en = 1'b0;
  logic [1:0] cnt_pin = 2'b11;
  logic [1:0] xint_pin = 2'b11;
  logic [1:0] ack_ovf = '0;
  logic [1:0] ack_xint = '0;
  logic [1:0] irq_ovf, irq_xint;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  dtu_top dut (.*);

  // {mode, preload hi, preload lo, ticks, exp hi, exp lo, exp flag0}
  localparam logic [55:0] VEC [6] = '{
    56'h01_FF_FE_03_00_01_01,   // R11 wrap
    56'h01_00_00_05_00_05_00,   // R11 plain count
    56'h00_00_1E_03_01_01_00,   // R10 prescaler carry into high byte
    56'h00_FF_FF_01_00_E0_01,   // R10 overflow keeps low bits 7:5
    56'h02_80_FE_03_80_81_01,   // R12 reload from high byte
    56'h03_12_FE_02_12_00_01    // R13 low byte only
  };

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(logic [2:0] a, logic [7:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(logic [2:0] a, output logic [7:0] d);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  task automatic ticks(int n);
    @(negedge clk);
    tick_en = 1'b1;
    repeat (n) @(negedge clk);
    tick_en = 1'b0;
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [7:0] d, h, l;
    idle(3);
    rst_n = 1'b1;
    idle(2);

    // R1 reset state
    for (int a = 0; a < 6; a++) begin
      rd(3'(a), d);
      chk("R1 reset register", d, 8'h00);
    end
    chk("R1 reset irqs", {irq_ovf, irq_xint}, 4'h0);

    // mode table walk on channel 0
    for (int v = 0; v < 6; v++) begin
      wr(0, VEC[v][55:48]);
      wr(1, 8'h00);
      wr(2, VEC[v][39:32]);
      wr(3, VEC[v][47:40]);
      wr(1, 8'h10);
      ticks(int'(VEC[v][31:24]));
      rd(3, h); rd(2, l);
      chk("R10-13 vector count", {h, l}, VEC[v][23:8]);
      rd(1, d);
      chk("R2 R6 vector flag0 bit5", d[5], VEC[v][0]);
      chk("R6 vector irq_ovf0", irq_ovf[0], VEC[v][0]);
      wr(1, 8'h00);
      rd(1, d);
      chk("R7 software clear of flag0", d[5], 1'b0);
    end

    // R5 run bit cleared holds the count
    wr(0, 8'h01); wr(2, 8'h10); wr(3, 8'h00); wr(1, 8'h00);
    ticks(5);
    rd(2, l);
    chk("R5 stopped count held", l, 8'h10);

    // R4 external source: edges counted, ticks ignored
    wr(0, 8'h05); wr(2, 8'h00); wr(3, 8'h00); wr(1, 8'h10);
    @(negedge clk); tick_en = 1'b1;
    for (int k = 0; k < 3; k++) begin
      @(negedge clk); cnt_pin[0] = 1'b0;
      idle(6);
      cnt_pin[0] = 1'b1;
      idle(6);
    end
    tick_en = 1'b0;
    idle(4);
    rd(2, l);
    chk("R4 one count per pin falling edge", l, 8'h03);

    // R3 gating by interrupt pin level
    wr(1, 8'h00); wr(0, 8'h09); wr(2, 8'h00); wr(1, 8'h10);
    @(negedge clk); xint_pin[0] = 1'b0;
    idle(4);
    ticks(5);
    rd(2, l);
    chk("R3 gate low blocks count", l, 8'h00);
    xint_pin[0] = 1'b1;
    idle(4);
    ticks(5);
    rd(2, l);
    chk("R3 gate high lets ticks count", l, 8'h05);

    // R7 hardware set beats software clear in the same cycle
    wr(1, 8'h00); wr(0, 8'h01); wr(2, 8'hFF); wr(3, 8'hFF); wr(1, 8'h10);
    @(negedge clk);
    tick_en = 1'b1; reg_wr = 1'b1; reg_addr = 3'd1; reg_wdata = 8'h10;
    @(negedge clk);
    tick_en = 1'b0; reg_wr = 1'b0;
    rd(1, d);
    chk("R7 set wins over write of 0", d[5], 1'b1);
    @(negedge clk); ack_ovf[0] = 1'b1;
    @(negedge clk); ack_ovf[0] = 1'b0;
    chk("R7 ack clears irq_ovf0", irq_ovf[0], 1'b0);

    // R7 hardware set beats ack in the same cycle
    wr(2, 8'hFF); wr(3, 8'hFF);
    @(negedge clk); tick_en = 1'b1; ack_ovf[0] = 1'b1;
    @(negedge clk); tick_en = 1'b0; ack_ovf[0] = 1'b0;
    chk("R7 set wins over ack", irq_ovf[0], 1'b1);
    wr(1, 8'h00);

    // R8 edge-type external interrupt
    wr(1, 8'h01);
    @(negedge clk); xint_pin[0] = 1'b0;
    idle(4);
    chk("R8 edge request", irq_xint[0], 1'b1);
    rd(1, d);
    chk("R2 R8 edge flag0 at bit1", d[1], 1'b1);
    @(negedge clk); ack_xint[0] = 1'b1;
    @(negedge clk); ack_xint[0] = 1'b0;
    chk("R8 ack clears edge request", irq_xint[0], 1'b0);
    xint_pin[0] = 1'b1;
    idle(4);

    // R9 level-type external interrupt
    wr(1, 8'h00);
    @(negedge clk); xint_pin[1] = 1'b0;
    idle(4);
    chk("R9 low level requests", irq_xint[1], 1'b1);
    rd(1, d);
    chk("R9 level does not latch flag1", d[3], 1'b0);
    xint_pin[1] = 1'b1;
    idle(4);
    chk("R9 high level releases", irq_xint[1], 1'b0);

    // R13 split mode: high byte on run1, channel 1 halted
    wr(0, 8'h33); wr(2, 8'h00); wr(3, 8'hFF); wr(4, 8'h00); wr(5, 8'h00);
    wr(1, 8'h50);
    ticks(1);
    rd(3, h); rd(2, l);
    chk("R13 split counts both bytes", {h, l}, 16'h0001);
    rd(1, d);
    chk("R13 high byte overflow sets flag1 only", {d[7], d[5]}, 2'b10);
    rd(4, l);
    chk("R13 channel 1 halted", l, 8'h00);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule